// File: doc/BRIEF.md
# Microcoded Fetch and Sequencing Controller

This controller drives a microprogrammed stack-machine core. It fetches one opcode byte from main memory at the program counter and advances the counter. It then dispatches to that opcode's microroutine and steps through it one microinstruction per cycle. The routine can skip ahead on a condition, jump over a fixed block, adjust the program counter, or stop the machine. At the end marker control goes back to fetch.

The controller owns the program counter, the opcode register and a sticky halt flag. The datapath is modelled only at this boundary. The controller sends a strobe with an operation id for each datapath micro-operation. The datapath sends back the address, data and stack-pointer register values, which the controller uses for its condition tests, and an overflow flag.

Top module: `ucode_sequencer`

## Requirements
- R1: While reset is held, and on its release, pc is 0, halted is 0, opcode is 0 and the controller is in the read step of fetch, with fetch_rd high.
- R2: Each fetch takes three cycles. In the first, fetch_rd is high and mem_data (the byte at address pc) is captured into opcode. In the second, pc increases by 1. The third is a dispatch cycle with no strobe. Step 0 of the routine runs in the cycle after dispatch.
- R3: Each datapath micro-operation takes one cycle, with dp_go high and dp_op giving its id. At all other times dp_op is 0. The ids are: 1 pc to address reg; 2 main-memory read at address reg; 3 top-of-stack to data reg; 4 stack pointer minus 4; 5 stack read at stack pointer; 6 data reg to top-of-stack; 7 top-of-stack to holding reg; 8 data minus holding; 9 data plus holding; 10 stack write at stack pointer; 11 data to scratch reg; 12 data logical right 24; 13 data left 2; 14 frame base to holding; 15 data to address reg; 16 stack read at address reg; 17 data to holding; 18 scratch to data; 19 data left 8; 20 data arithmetic right 24; 21 stack write at address reg; 22 address reg minus stack pointer.
- R4: A condition test that is true skips the next N microinstructions. A false test moves to the next microinstruction. There are four tests, each on signed DW-bit values: code 0 is address reg nonzero, with N=1; code 1 is data reg negative, N=2; code 2 is data reg zero, N=2; code 3 is stack pointer negative, N=2.
- R5: A branch microinstruction jumps over the three microinstructions that follow it.
- R6: The halt flag is set by dp_ovf being high in a cycle when dp_go is high. It is also set by signed overflow of pc, meaning its MSB goes from 0 to 1, on a fetch increment or a routine pc step.
- R7: Three microinstructions act on pc and halt directly. The pc-load step loads pc with the upper half of mdr_val, zero-extended. The pc-clear step sets pc to 0. The stop step sets halted.
- R8: Once halted is high, fetch_rd and dp_go stay low, and pc, opcode and halted hold their values until reset.
- R9: An opcode with no routine acts as a no-op. Fetch of the next opcode starts in the cycle after dispatch.
- R10: At the end marker no strobe is issued, and fetch_rd rises in the next cycle.
- R11: Routines are listed below in step order. Numbers are R3 ids. Tc is a test with code c, B is a branch, +n steps pc by n, L is pc-load, Z is pc-clear, H is stop, and every routine ends with the end marker.
  - 0x00: (empty)
  - 0xFC: H
  - 0xA7: 1 2 Z L
  - 0x57: 4 T3 5 6
  - 0x99: 3 4 T2 +2 B 1 2 L T3 5 6
  - 0x9B: as 0x99 but with T1
  - 0x9F: 7 4 5 4 8 T2 +2 B 1 2 L T3 5 6
  - 0x60: 7 4 5 9 6 10
  - 0x64: 7 4 5 8 6 10
  - 0x84: 1 2 11 12 13 14 9 15 16 17 18 19 20 9 21 +2 22 T0 6

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_data | input | 8 | Main-memory byte at address pc |
| mar_val | input | DW | Address register value from datapath |
| mdr_val | input | DW | Data register value from datapath |
| sp_val | input | DW | Stack pointer value from datapath |
| dp_ovf | input | 1 | Datapath overflow for the current strobed operation |
| pc | output | PC_W | Program counter, also the fetch address |
| opcode | output | 8 | Last fetched opcode byte |
| fetch_rd | output | 1 | Opcode read strobe |
| dp_go | output | 1 | Datapath micro-operation strobe |
| dp_op | output | 5 | Datapath micro-operation id |
| halted | output | 1 | Halt status flag |

## Verification
The bench builds the controller with DW=32, UPC_W=5 and a narrow PC_W=16. With PC_W=16, a pc-load from the upper half of the data register lands pc at 0x7FFF. The next fetch increment then crosses into the sign bit, so pc overflow halting can be reached in a few cycles. The 64-byte bench memory is indexed by the low pc bits. This lets a far branch target such as 0x8006 alias onto a stop opcode placed low in memory.

// File: rtl/ucode_sequencer.sv
module ucode_sequencer #(
  parameter int DW    = 32,
  parameter int PC_W  = 32,
  parameter int UPC_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [7:0]      mem_data,
  input  logic [DW-1:0]   mar_val,
  input  logic [DW-1:0]   mdr_val,
  input  logic [DW-1:0]   sp_val,
  input  logic            dp_ovf,
  output logic [PC_W-1:0] pc,
  output logic [7:0]      opcode,
  output logic            fetch_rd,
  output logic            dp_go,
  output logic [4:0]      dp_op,
  output logic            halted
);
  localparam int ROM_W = 8 << UPC_W;
  localparam logic [2:0] K_END = 3'd0, K_DP = 3'd1, K_TST = 3'd2, K_BR = 3'd3,
                         K_INC = 3'd4, K_LD = 3'd5, K_CLR = 3'd6, K_HLT = 3'd7;

  typedef enum logic [1:0] {PH_RD, PH_INC, PH_DSP, PH_EX} phase_t;

  phase_t           ph;
  logic [UPC_W-1:0] upc, adv;
  logic [ROM_W-1:0] body;
  logic [7:0]       uw;
  logic [2:0]       kind;
  logic [4:0]       arg;
  logic             hit, pc_ovf;
  logic [PC_W-1:0]  pc_sum;

  // routine bodies, listed last step first (step 0 in the low byte)
  always_comb begin
    case (opcode)
      8'hFC:   body = ROM_W'({8'h00, 8'hE0});
      8'hA7:   body = ROM_W'({8'h00, 8'hA0, 8'hC0, 8'h22, 8'h21});
      8'h57:   body = ROM_W'({8'h00, 8'h26, 8'h25, 8'h43, 8'h24});
      8'h99:   body = ROM_W'({8'h00, 8'h26, 8'h25, 8'h43, 8'hA0, 8'h22, 8'h21,
                              8'h60, 8'h82, 8'h42, 8'h24, 8'h23});
      8'h9B:   body = ROM_W'({8'h00, 8'h26, 8'h25, 8'h43, 8'hA0, 8'h22, 8'h21,
                              8'h60, 8'h82, 8'h41, 8'h24, 8'h23});
      8'h9F:   body = ROM_W'({8'h00, 8'h26, 8'h25, 8'h43, 8'hA0, 8'h22, 8'h21,
                              8'h60, 8'h82, 8'h42, 8'h28, 8'h24, 8'h25, 8'h24, 8'h27});
      8'h60:   body = ROM_W'({8'h00, 8'h2A, 8'h26, 8'h29, 8'h25, 8'h24, 8'h27});
      8'h64:   body = ROM_W'({8'h00, 8'h2A, 8'h26, 8'h28, 8'h25, 8'h24, 8'h27});
      8'h84:   body = ROM_W'({8'h00, 8'h26, 8'h40, 8'h36, 8'h82, 8'h35, 8'h29,
                              8'h34, 8'h33, 8'h32, 8'h31, 8'h30, 8'h2F, 8'h29,
                              8'h2E, 8'h2D, 8'h2C, 8'h2B, 8'h22, 8'h21});
      default: body = '0;
    endcase
  end

  assign uw   = body[{upc, 3'b000} +: 8];
  assign kind = uw[7:5];
  assign arg  = uw[4:0];

  always_comb begin
    case (arg[1:0])
      2'd0:    hit = (mar_val != '0);
      2'd1:    hit = ($signed(mdr_val) < $signed({DW{1'b0}}));
      2'd2:    hit = (mdr_val == '0);
      default: hit = ($signed(sp_val) < $signed({DW{1'b0}}));
    endcase
    if (!hit)                adv = UPC_W'(1);
    else if (arg[1:0] == 2'd0) adv = UPC_W'(2);
    else                     adv = UPC_W'(3);
  end

  assign pc_sum = pc + ((ph == PH_INC) ? PC_W'(1) : PC_W'(arg));
  assign pc_ovf = !pc[PC_W-1] && pc_sum[PC_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= PH_RD;
      upc    <= '0;
      opcode <= '0;
      halted <= 1'b0;
      pc     <= '0;
    end else if (!halted) begin
      case (ph)
        PH_RD:  begin opcode <= mem_data; ph <= PH_INC; end
        PH_INC: begin pc <= pc_sum; halted <= pc_ovf; ph <= PH_DSP; end
        PH_DSP: begin upc <= '0; ph <= PH_EX; end
        default: begin
          case (kind)
            K_END: ph <= PH_RD;
            K_DP:  begin upc <= upc + 1'b1; halted <= dp_ovf; end
            K_TST: upc <= upc + adv;
            K_BR:  upc <= upc + UPC_W'(4);
            K_INC: begin pc <= pc_sum; halted <= pc_ovf; upc <= upc + 1'b1; end
            K_LD:  begin pc <= PC_W'(mdr_val[DW-1:DW/2]); upc <= upc + 1'b1; end
            K_CLR: begin pc <= '0; upc <= upc + 1'b1; end
            default: begin halted <= 1'b1; upc <= upc + 1'b1; end
          endcase
        end
      endcase
    end
  end

  assign fetch_rd = !halted && (ph == PH_RD);
  assign dp_go    = !halted && (ph == PH_EX) && (kind == K_DP);
  assign dp_op    = dp_go ? arg : 5'd0;

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n) halted |-> !fetch_rd && !dp_go); // R8
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n) halted |=> halted && $stable(pc) && $stable(opcode)); // R8
  AST_FETCH_STEP: assert property (@(posedge clk) disable iff (!rst_n) fetch_rd |=> ##1 (pc == $past(pc, 2) + 1'b1)); // R2
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n) !(fetch_rd && dp_go)); // R3
  AST_OVF_HALT: assert property (@(posedge clk) disable iff (!rst_n) dp_go && dp_ovf |=> halted); // R6
  AST_OP_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !dp_go |-> dp_op == 5'd0); // R3
endmodule

// File: tb/sim_ucode_sequencer.sv
module sim_ucode_sequencer;
  localparam int CLK_P = 10;
  typedef int iq_t[$];

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] mar_v = '0, mdr_v = '0, sp_v = '0;
  logic        ovf = 1'b0;
  logic [7:0]  prog [0:63];
  logic [15:0] pc;
  logic [7:0]  opcode, mem_data;
  logic        fetch_rd, dp_go, halted;
  logic [4:0]  dp_op;

  int    n_cmp = 0, n_bad = 0, cyc = 0;
  bit    armed = 1'b0;
  string cur_req = "R1";

  always #(CLK_P/2) clk = ~clk;
  assign mem_data = prog[pc[5:0]];

  ucode_sequencer #(.DW(32), .PC_W(16), .UPC_W(5)) u0 (
    .clk(clk), .rst_n(rst_n), .mem_data(mem_data), .mar_val(mar_v), .mdr_val(mdr_v),
    .sp_val(sp_v), .dp_ovf(ovf), .pc(pc), .opcode(opcode), .fetch_rd(fetch_rd),
    .dp_go(dp_go), .dp_op(dp_op), .halted(halted));

  // tokens: 1..22 datapath id, 100+c test, 200 branch, 300+n pc step, 400 load, 401 clear, 500 stop, -1 end
  function automatic iq_t routine(input logic [7:0] op);
    case (op)
      8'hFC: return {500, -1};
      8'hA7: return {1, 2, 401, 400, -1};
      8'h57: return {4, 103, 5, 6, -1};
      8'h99: return {3, 4, 102, 302, 200, 1, 2, 400, 103, 5, 6, -1};
      8'h9B: return {3, 4, 101, 302, 200, 1, 2, 400, 103, 5, 6, -1};
      8'h9F: return {7, 4, 5, 4, 8, 102, 302, 200, 1, 2, 400, 103, 5, 6, -1};
      8'h60: return {7, 4, 5, 9, 6, 10, -1};
      8'h64: return {7, 4, 5, 8, 6, 10, -1};
      8'h84: return {1, 2, 11, 12, 13, 14, 9, 15, 16, 17, 18, 19, 20, 9, 21, 302, 22, 100, 6, -1};
      default: return {-1};
    endcase
  endfunction

  int          m_ph, m_k;
  iq_t         m_q;
  logic [15:0] m_pc, nxt;
  logic        m_h;
  logic [7:0]  m_op;

  function automatic int cur_tok();
    if (m_ph == 3 && m_k < m_q.size()) return m_q[m_k];
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_k = 0; m_pc = '0; m_h = 1'b0; m_op = '0; m_q = {};
    end else if (!m_h) begin
      int t;
      t = cur_tok();
      case (m_ph)
        0: begin m_op = mem_data; m_ph = 1; end
        1: begin nxt = m_pc + 16'd1; m_h = !m_pc[15] && nxt[15]; m_pc = nxt; m_ph = 2; end
        2: begin m_q = routine(m_op); m_k = 0; m_ph = 3; end
        default: begin
          if (t == -1) m_ph = 0;
          else if (t >= 1 && t <= 22) begin if (ovf) m_h = 1'b1; m_k++; end
          else if (t >= 100 && t < 200) begin
            bit h;
            case (t - 100)
              0: h = (mar_v != 0);
              1: h = ($signed(mdr_v) < 0);
              2: h = (mdr_v == 0);
              default: h = ($signed(sp_v) < 0);
            endcase
            m_k += h ? ((t == 100) ? 2 : 3) : 1;
          end
          else if (t == 200) m_k += 4;
          else if (t >= 300 && t < 400) begin
            nxt = m_pc + 16'(t - 300); if (!m_pc[15] && nxt[15]) m_h = 1'b1; m_pc = nxt; m_k++;
          end
          else if (t == 400) begin m_pc = mdr_v[31:16]; m_k++; end
          else if (t == 401) begin m_pc = '0; m_k++; end
          else begin m_h = 1'b1; m_k++; end
        end
      endcase
    end
  end

  task automatic chk(input string f, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, f, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (armed) begin
      int t;
      bit eg;
      t  = cur_tok();
      eg = !m_h && m_ph == 3 && t >= 1 && t <= 22;
      chk("fetch_rd", 32'(fetch_rd), 32'(!m_h && m_ph == 0));
      chk("dp_go", 32'(dp_go), 32'(eg));
      chk("dp_op", 32'(dp_op), eg ? 32'(t) : 32'd0);
      chk("pc", 32'(pc), 32'(m_pc));
      chk("opcode", 32'(opcode), 32'(m_op));
      chk("halted", 32'(halted), 32'(m_h));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic setup(input string tag, input logic [31:0] mr, input logic [31:0] md,
                       input logic [31:0] s, input logic o);
    @(negedge clk); #2;
    cur_req = tag;
    rst_n = 1'b0;
    for (int i = 0; i < 64; i++) prog[i] = 8'h00;
    mar_v = mr; mdr_v = md; sp_v = s; ovf = o;
  endtask

  task automatic go(input int n);
    @(negedge clk); #2 rst_n = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) prog[i] = 8'h00;
    @(posedge clk); #1 armed = 1'b1;
    // R1 R2 R3 R10 R11: nop, add, subtract, stop
    setup("R1 R2 R3 R10 R11", 0, 0, 0, 0);
    prog[0] = 8'h00; prog[1] = 8'h60; prog[2] = 8'h64; prog[3] = 8'hFC;
    go(45);
    chk("R7 stop sets halt", 32'(halted), 1);
    // R9: undefined opcodes
    setup("R9", 0, 0, 0, 0);
    prog[0] = 8'h42; prog[1] = 8'hB0; prog[2] = 8'hFC;
    go(20);
    chk("R9 pc after two no-ops and stop", 32'(pc), 3);
    // R4 R5: zero test false, branch taken
    setup("R4 R5 zero-test false", 0, 32'h0010_0001, 0, 0);
    prog[0] = 8'h99; prog[3] = 8'hFC;
    go(30);
    chk("R5 fall-through pc", 32'(pc), 4);
    // R4 R7: zero test true, pc load of zero
    setup("R4 R7 zero-test true", 0, 0, 0, 0);
    prog[0] = 8'h99;
    go(60);
    // R4 R5 R7: negative test true, far target aliases to stop
    setup("R4 R7 negative-test", 0, 32'h8006_0000, 32'hFFFF_FFFC, 0);
    prog[0] = 8'h9B; prog[6] = 8'hFC;
    go(40);
    chk("R7 loaded target then stop", 32'(pc), 16'h8007);
    // R4 R5: compare-equal false
    setup("R4 R5 compare", 0, 5, 0, 0);
    prog[0] = 8'h9F; prog[3] = 8'hFC;
    go(40);
    // R4: address-nonzero skip of one
    setup("R4 skip1 false", 0, 0, 0, 0);
    prog[0] = 8'h84; prog[3] = 8'hFC;
    go(40);
    setup("R4 skip1 true", 4, 0, 0, 0);
    prog[0] = 8'h84; prog[3] = 8'hFC;
    go(40);
    // R4: stack pointer negative
    setup("R4 sp-negative", 0, 0, 32'hFFFF_FFF0, 0);
    prog[0] = 8'h57; prog[1] = 8'h57; prog[2] = 8'hFC;
    go(30);
    // R6 R8: datapath overflow halts and freezes
    setup("R6 R8 datapath overflow", 0, 0, 0, 1);
    prog[0] = 8'h60;
    go(20);
    chk("R6 overflow halts", 32'(halted), 1);
    chk("R8 pc frozen", 32'(pc), 1);
    // R6 R7 R8: pc clear+load to 0x7FFF, increment overflows
    setup("R6 R7 R8 pc overflow", 0, 32'h7FFF_0000, 0, 0);
    prog[0] = 8'hA7;
    go(25);
    chk("R6 pc overflow halts", 32'(halted), 1);
    chk("R8 pc held after overflow", 32'(pc), 16'h8000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule